// File: doc/BRIEF.md
# ADC Interrupt Status Flag Register

This block is the event and interrupt flag register of an ADC controller. The conversion engine, sequencer and calibration logic each report events as single-cycle pulses. The block latches each pulse into a sticky flag. Software reads the flags over a simple word-addressed register bus and clears each one by writing 1 to its bit.

An interrupt enable register uses the same bit layout as the flag register. It is masked against the flags and the result is reduced to one level-sensitive interrupt line.

The block also holds the latest conversion result. Reading that result clears the conversion-done flag. An overrun flag records when a result arrives before the previous one was consumed.

Channel configuration and start requests pass through a handshake. A configuration write is accepted only when no earlier configuration is still waiting to be applied and the configuration-ready flag is clear. A start request is accepted only when the converter is enabled and no configuration is pending.

Top module: `adcstat_regs`

## Requirements
- R1: After reset, every flag, the interrupt enable register, the channel configuration, the enable level and the irq output are all 0. The cfg_load and conv_start outputs are low.
- R2: The word addresses are 0 FLAGS, 1 IRQ_EN, 2 CHANCFG, 3 CTRL and 4 DATA. The FLAGS bits are: 0 ready, 1 sampling done, 2 conversion done, 3 sequence done, 4 overrun, 5 to 7 watchdog 1 to 3, 8 calibration done, 9 configuration ready. A bus write to FLAGS clears every flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R3: When a hardware set and a software clear reach the same flag in the same cycle, the flag ends set.
- R4: The ready flag sets on ev_ready only while the enable level (CTRL bit 0, written at any time) is 1. An ev_ready pulse while the enable level is 0 leaves the flag at 0.
- R5: An ev_conv_end pulse sets the conversion-done flag and captures ev_result into the DATA register.
- R6: A bus read of DATA returns the captured result, zero-extended. At the same edge the read clears the conversion-done flag.
- R7: An ev_conv_end pulse sets the overrun flag when the conversion-done flag is already set and is not being cleared in that same cycle. The clear may come from a write to FLAGS or from a read of DATA.
- R8: Pulses on ev_smp_end, ev_seq_end, ev_wdog[k] and ev_cal_end set flag bits 1, 3, 5+k and 8 respectively.
- R9: A write to CHANCFG is accepted only when no configuration is pending and the configuration-ready flag is 0. CHANCFG holds the channel mask in bits NCH-1:0, the mode in bit 30 and the scan direction in bit 31. An accepted write updates cfg_chan_mask, cfg_mode and cfg_dir, gives a one-cycle cfg_load pulse in the next cycle, and marks a configuration as pending. A write that is not accepted changes nothing and gives no pulse.
- R10: An ev_cfg_applied pulse while a configuration is pending sets the configuration-ready flag and ends the pending state. An ev_cfg_applied pulse with nothing pending has no effect.
- R11: A CTRL write with bit 1 set gives a one-cycle conv_start pulse in the next cycle, but only when the enable level was already 1 and no configuration is pending.
- R12: The irq output is 1 exactly when some flag and its IRQ_EN bit are both 1. IRQ_EN reads back all 32 bits as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write access |
| bus_rd | input | 1 | Read access |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read |
| ev_ready | input | 1 | Converter can accept requests |
| ev_smp_end | input | 1 | Sampling phase finished |
| ev_conv_end | input | 1 | Channel conversion finished |
| ev_result | input | DATA_W | Result that comes with ev_conv_end |
| ev_seq_end | input | 1 | Channel sequence finished |
| ev_wdog | input | 3 | Analog watchdog hits 1 to 3 |
| ev_cal_end | input | 1 | Calibration finished |
| ev_cfg_applied | input | 1 | Sequencer has applied the configuration |
| conv_enable | output | 1 | Enable level |
| conv_start | output | 1 | Accepted start pulse |
| cfg_load | output | 1 | Accepted configuration pulse |
| cfg_chan_mask | output | NCH | Channel select mask |
| cfg_mode | output | 1 | Selection mode |
| cfg_dir | output | 1 | Scan direction |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest state to reach is a configuration write that arrives during the handshake. One case is a write while a configuration is still pending. The other is a write after the configuration-ready flag has risen but before software has cleared it. The stimulus first issues one accepted write and holds off the applied pulse. It then repeats the configuration and start writes at each stage of the handshake, checking the outputs after each one.

A second hard case is a conversion completion that lands in the same cycle as the clear of the conversion flag. The vector table aligns the event pulse with a write-1 to FLAGS to reach it.

// File: rtl/adcstat_pkg.sv
package adcstat_pkg;
  localparam int REG_W  = 32;
  localparam int NFLAG  = 10;
  localparam int NWDOG  = 3;
  localparam int ADDR_W = 3;

  localparam int FL_RDY = 0;
  localparam int FL_SMP = 1;
  localparam int FL_EOC = 2;
  localparam int FL_EOS = 3;
  localparam int FL_OVR = 4;
  localparam int FL_WD0 = 5;
  localparam int FL_CAL = 8;
  localparam int FL_CC  = 9;

  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd0;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CFG   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd4;

  localparam int CFG_MODE_BIT = 30;
  localparam int CFG_DIR_BIT  = 31;

  // next value of one sticky flag: a set beats a clear
  function automatic logic flag_step(logic q, logic set, logic clr);
    return set | (q & ~clr);
  endfunction

  // a new result is lost when the old one is still unread and not consumed now
  function automatic logic overrun_hit(logic ev, logic q, logic clr);
    return ev & q & ~clr;
  endfunction
endpackage

// File: rtl/adcstat_flagbank.sv
module adcstat_flagbank #(
  parameter int NF = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  output logic [NF-1:0] flags_o
);
  import adcstat_pkg::*;

  for (genvar i = 0; i < NF; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= flag_step(q, set_i[i], clr_i[i]);
    end
    assign flags_o[i] = q;

    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flags_o[i]);
    p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flags_o[i]);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[i] && !set_i[i]) |=> $stable(flags_o[i]));
  end
endmodule

// File: rtl/adcstat_cfggate.sv
module adcstat_cfggate #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr_i,
  input  logic [NCH-1:0] cfg_mask_i,
  input  logic           cfg_mode_i,
  input  logic           cfg_dir_i,
  input  logic           ctrl_wr_i,
  input  logic           ctrl_en_i,
  input  logic           ctrl_start_i,
  input  logic           cc_flag_i,
  input  logic           applied_i,
  output logic           cc_set_o,
  output logic           conv_en_o,
  output logic           start_o,
  output logic           cfg_load_o,
  output logic [NCH-1:0] cfg_mask_o,
  output logic           cfg_mode_o,
  output logic           cfg_dir_o
);
  logic busy_q;
  logic cfg_take;
  logic start_take;

  assign cfg_take   = cfg_wr_i & ~busy_q & ~cc_flag_i;
  assign start_take = ctrl_wr_i & ctrl_start_i & conv_en_o & ~busy_q;
  assign cc_set_o   = applied_i & busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      conv_en_o  <= 1'b0;
      start_o    <= 1'b0;
      cfg_load_o <= 1'b0;
      cfg_mask_o <= '0;
      cfg_mode_o <= 1'b0;
      cfg_dir_o  <= 1'b0;
    end else begin
      start_o    <= start_take;
      cfg_load_o <= cfg_take;
      if (ctrl_wr_i) conv_en_o <= ctrl_en_i;
      if (cfg_take) begin
        busy_q     <= 1'b1;
        cfg_mask_o <= cfg_mask_i;
        cfg_mode_o <= cfg_mode_i;
        cfg_dir_o  <= cfg_dir_i;
      end else if (cc_set_o) begin
        busy_q <= 1'b0;
      end
    end
  end

  p_cfg_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_i && (busy_q || cc_flag_i)) |=> ($stable(cfg_mask_o) && !cfg_load_o));
  p_cfg_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load_o |=> !cfg_load_o);
  p_start_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q || !conv_en_o) |=> !start_o);
  p_stray_apply_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (applied_i && !busy_q) |-> !cc_set_o);
endmodule

// File: rtl/adcstat_regs.sv
module adcstat_regs #(
  parameter int NCH    = 8,
  parameter int DATA_W = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_sel,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [adcstat_pkg::ADDR_W-1:0] bus_addr,
  input  logic [31:0]                    bus_wdata,
  output logic [31:0]                    bus_rdata,
  input  logic                           ev_ready,
  input  logic                           ev_smp_end,
  input  logic                           ev_conv_end,
  input  logic [DATA_W-1:0]              ev_result,
  input  logic                           ev_seq_end,
  input  logic [2:0]                     ev_wdog,
  input  logic                           ev_cal_end,
  input  logic                           ev_cfg_applied,
  output logic                           conv_enable,
  output logic                           conv_start,
  output logic                           cfg_load,
  output logic [NCH-1:0]                 cfg_chan_mask,
  output logic                           cfg_mode,
  output logic                           cfg_dir,
  output logic                           irq
);
  import adcstat_pkg::*;

  localparam int NF = NFLAG;

  logic wr_flags, wr_ien, wr_cfg, wr_ctrl, rd_data;
  logic [NF-1:0]     flag_set, flag_clr, flags;
  logic [REG_W-1:0]  ien_q;
  logic [DATA_W-1:0] data_q;
  logic              eoc_clr, ovr_set, cc_set;

  assign wr_flags = bus_sel & bus_wr & (bus_addr == A_FLAGS);
  assign wr_ien   = bus_sel & bus_wr & (bus_addr == A_IEN);
  assign wr_cfg   = bus_sel & bus_wr & (bus_addr == A_CFG);
  assign wr_ctrl  = bus_sel & bus_wr & (bus_addr == A_CTRL);
  assign rd_data  = bus_sel & bus_rd & ~bus_wr & (bus_addr == A_DATA);

  assign eoc_clr = rd_data | (wr_flags & bus_wdata[FL_EOC]);
  assign ovr_set = overrun_hit(ev_conv_end, flags[FL_EOC], eoc_clr);

  always_comb begin
    flag_clr = wr_flags ? bus_wdata[NF-1:0] : '0;
    flag_clr[FL_EOC] = eoc_clr;
    flag_set = '0;
    flag_set[FL_RDY] = ev_ready & conv_enable;
    flag_set[FL_SMP] = ev_smp_end;
    flag_set[FL_EOC] = ev_conv_end;
    flag_set[FL_EOS] = ev_seq_end;
    flag_set[FL_OVR] = ovr_set;
    flag_set[FL_WD0 +: NWDOG] = ev_wdog;
    flag_set[FL_CAL] = ev_cal_end;
    flag_set[FL_CC]  = cc_set;
  end

  adcstat_flagbank #(.NF(NF)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (flag_set),
    .clr_i   (flag_clr),
    .flags_o (flags)
  );

  adcstat_cfggate #(.NCH(NCH)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_i     (wr_cfg),
    .cfg_mask_i   (bus_wdata[NCH-1:0]),
    .cfg_mode_i   (bus_wdata[CFG_MODE_BIT]),
    .cfg_dir_i    (bus_wdata[CFG_DIR_BIT]),
    .ctrl_wr_i    (wr_ctrl),
    .ctrl_en_i    (bus_wdata[0]),
    .ctrl_start_i (bus_wdata[1]),
    .cc_flag_i    (flags[FL_CC]),
    .applied_i    (ev_cfg_applied),
    .cc_set_o     (cc_set),
    .conv_en_o    (conv_enable),
    .start_o      (conv_start),
    .cfg_load_o   (cfg_load),
    .cfg_mask_o   (cfg_chan_mask),
    .cfg_mode_o   (cfg_mode),
    .cfg_dir_o    (cfg_dir)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q  <= '0;
      data_q <= '0;
    end else begin
      if (wr_ien)      ien_q  <= bus_wdata;
      if (ev_conv_end) data_q <= ev_result;
    end
  end

  assign irq = |(flags & ien_q[NF-1:0]);

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && bus_rd) begin
      case (bus_addr)
        A_FLAGS: bus_rdata[NF-1:0] = flags;
        A_IEN:   bus_rdata = ien_q;
        A_CFG: begin
          bus_rdata[NCH-1:0]      = cfg_chan_mask;
          bus_rdata[CFG_MODE_BIT] = cfg_mode;
          bus_rdata[CFG_DIR_BIT]  = cfg_dir;
        end
        A_CTRL:  bus_rdata[0] = conv_enable;
        A_DATA:  bus_rdata[DATA_W-1:0] = data_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  p_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_conv_end && flags[FL_EOC] && !eoc_clr) |=> flags[FL_OVR]);
  p_rdy_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ready && !conv_enable && !flags[FL_RDY]) |=> !flags[FL_RDY]);
  p_data_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !ev_conv_end) |=> !flags[FL_EOC]);
  p_data_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_conv_end |=> (data_q == $past(ev_result) && flags[FL_EOC]));
endmodule

// File: tb/sim_adcstat_regs.sv
`timescale 1ns/1ps
module sim_adcstat_regs;
  localparam int NCH = 8;
  localparam int DW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic ev_ready = 0, ev_smp_end = 0, ev_conv_end = 0, ev_seq_end = 0;
  logic ev_cal_end = 0, ev_cfg_applied = 0;
  logic [2:0] ev_wdog = '0;
  logic [DW-1:0] ev_result = '0;
  logic conv_enable, conv_start, cfg_load, cfg_mode, cfg_dir, irq;
  logic [NCH-1:0] cfg_chan_mask;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  adcstat_regs #(.NCH(NCH), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_ready(ev_ready), .ev_smp_end(ev_smp_end), .ev_conv_end(ev_conv_end),
    .ev_result(ev_result), .ev_seq_end(ev_seq_end), .ev_wdog(ev_wdog),
    .ev_cal_end(ev_cal_end), .ev_cfg_applied(ev_cfg_applied),
    .conv_enable(conv_enable), .conv_start(conv_start), .cfg_load(cfg_load),
    .cfg_chan_mask(cfg_chan_mask), .cfg_mode(cfg_mode), .cfg_dir(cfg_dir), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  // read without consuming an edge (no side effect except on DATA)
  task automatic peek(logic [2:0] a, output logic [31:0] d);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0; bus_rd = 0;
  endtask

  // read held across one edge so a DATA read takes effect
  task automatic rd_edge(logic [2:0] a, output logic [31:0] d);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    tick();
    bus_sel = 0; bus_rd = 0;
  endtask

  task automatic pulse_ev(logic [9:0] ev, logic [DW-1:0] res);
    ev_ready = ev[0]; ev_smp_end = ev[1]; ev_conv_end = ev[2]; ev_seq_end = ev[3];
    ev_wdog = ev[7:5]; ev_cal_end = ev[8]; ev_cfg_applied = ev[9]; ev_result = res;
  endtask

  // {events[29:20], write-1 clear mask[19:10], expected flags[9:0]}
  localparam logic [29:0] VEC [10] = '{
    {10'h001, 10'h000, 10'h001},  // R4 ready with enable
    {10'h006, 10'h000, 10'h007},  // R5 R8 sampling + conversion, R2 write 0 holds
    {10'h004, 10'h000, 10'h017},  // R7 overrun on unread result
    {10'h000, 10'h014, 10'h003},  // R2 clear conv + overrun
    {10'h048, 10'h001, 10'h04A},  // R8 sequence + wdog2
    {10'h1A0, 10'h002, 10'h1E8},  // R8 wdog1, wdog3, calibration
    {10'h040, 10'h040, 10'h1E8},  // R3 set beats clear
    {10'h004, 10'h004, 10'h1EC},  // R3 conv set beats clear
    {10'h004, 10'h004, 10'h1EC},  // R7 no overrun when cleared same cycle
    {10'h000, 10'h3FF, 10'h000}   // R2 clear all
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    peek(3'd0, rv); chk("R1 flags", rv, 32'h0);
    peek(3'd1, rv); chk("R1 ien", rv, 32'h0);
    peek(3'd2, rv); chk("R1 cfg", rv, 32'h0);
    chk("R1 outs", {28'h0, irq, conv_enable, cfg_load, conv_start}, 32'h0);

    // R4 ready ignored while disabled
    pulse_ev(10'h001, '0); tick(); pulse_ev(10'h000, '0);
    peek(3'd0, rv); chk("R4 disabled ready", rv, 32'h0);
    wr(3'd3, 32'h1);
    chk("R4 enable level", {31'h0, conv_enable}, 32'h1);

    // R12 all sources enabled, readback
    wr(3'd1, 32'hFFFF_FFFF);
    peek(3'd1, rv); chk("R12 ien readback", rv, 32'hFFFF_FFFF);

    for (int i = 0; i < 10; i++) begin
      pulse_ev(VEC[i][29:20], DW'(i));
      if (VEC[i][19:10] != 0) begin
        bus_sel = 1; bus_wr = 1; bus_addr = 3'd0; bus_wdata = {22'h0, VEC[i][19:10]};
      end
      tick();
      bus_sel = 0; bus_wr = 0; bus_wdata = '0;
      pulse_ev(10'h000, '0);
      peek(3'd0, rv);
      chk($sformatf("R2/R3/R7/R8 vector %0d", i), rv, {22'h0, VEC[i][9:0]});
      chk($sformatf("R12 irq vector %0d", i), {31'h0, irq}, {31'h0, |VEC[i][9:0]});
    end

    // R5 R6 capture and read-to-clear
    pulse_ev(10'h004, 12'h5A5); tick(); pulse_ev(10'h000, '0);
    rd_edge(3'd4, rv); chk("R6 data value", rv, 32'h0000_05A5);
    peek(3'd0, rv); chk("R6 read clears conv flag", rv, 32'h0);
    pulse_ev(10'h004, 12'h123); tick(); pulse_ev(10'h000, '0);
    peek(3'd0, rv); chk("R7 no overrun after read", rv, 32'h004);
    peek(3'd4, rv); chk("R5 data captured", rv, 32'h0000_0123);
    wr(3'd0, 32'h3FF);

    // R9 R10 R11 configuration handshake
    wr(3'd2, 32'h8000_000F);
    chk("R9 load pulse", {31'h0, cfg_load}, 32'h1);
    chk("R9 mask", {24'h0, cfg_chan_mask}, 32'h0F);
    chk("R9 dir/mode", {30'h0, cfg_dir, cfg_mode}, 32'h2);
    tick();
    chk("R9 load one cycle", {31'h0, cfg_load}, 32'h0);
    wr(3'd2, 32'h0000_00F0);
    chk("R9 pending ignores write", {23'h0, cfg_load, cfg_chan_mask}, 32'h00F);
    wr(3'd3, 32'h3);
    chk("R11 start blocked while pending", {31'h0, conv_start}, 32'h0);
    pulse_ev(10'h200, '0); tick(); pulse_ev(10'h000, '0);
    peek(3'd0, rv); chk("R10 cfg ready flag", rv, 32'h200);
    wr(3'd2, 32'h0000_0033);
    chk("R9 ready flag set ignores write", {23'h0, cfg_load, cfg_chan_mask}, 32'h00F);
    wr(3'd3, 32'h3);
    chk("R11 start accepted", {31'h0, conv_start}, 32'h1);
    tick();
    chk("R11 start one cycle", {31'h0, conv_start}, 32'h0);
    wr(3'd0, 32'h200);
    wr(3'd2, 32'h4000_0033);
    chk("R9 accepted after clear", {22'h0, cfg_load, cfg_mode, cfg_chan_mask}, 32'h333);
    pulse_ev(10'h200, '0); tick(); pulse_ev(10'h000, '0);
    wr(3'd0, 32'h200);
    pulse_ev(10'h200, '0); tick(); pulse_ev(10'h000, '0);
    peek(3'd0, rv); chk("R10 stray applied ignored", rv, 32'h0);
    wr(3'd3, 32'h0);
    wr(3'd3, 32'h2);
    chk("R11 start blocked when disabled", {30'h0, conv_enable, conv_start}, 32'h0);

    // R12 masking
    wr(3'd1, 32'h0000_0008);
    peek(3'd1, rv); chk("R12 ien readback mask", rv, 32'h8);
    pulse_ev(10'h008, '0); tick(); pulse_ev(10'h000, '0);
    chk("R12 irq on enabled flag", {31'h0, irq}, 32'h1);
    pulse_ev(10'h020, '0); tick(); pulse_ev(10'h000, '0);
    wr(3'd0, 32'h008);
    peek(3'd0, rv); chk("R12 masked flag present", rv, 32'h020);
    chk("R12 irq masked", {31'h0, irq}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule